// File: doc/BRIEF.md
# Multiplexed External Memory Bus Sequencer

This block turns single access requests into timed external bus cycles for an 8-bit controller whose machine cycle is 12 clocks long. The low address byte and the data share one 8-bit port. The high address byte sits on a second port. Four strobes mark the phases of each cycle: an active-high address latch strobe, an active-low program read strobe, an active-low data read strobe and an active-low data write strobe. Every strobe edge falls on a fixed whole-clock offset from the start of the access, so an external address latch and memory can be timed directly from the clock.

Each machine cycle splits into two 6-clock slots. A code fetch fills one slot and may start at the start of either slot. A data read or write fills a whole machine cycle and starts only at the machine-cycle boundary, in place of the two fetches it displaces. Requests use a valid/ready handshake that carries a kind, an address and write data. Fetch and read data return with a one-clock valid pulse. The shared port is modelled as a driven value, an output enable and a sampled input, so the pad tristate stays outside the block.

Top module: `mx_bus_seq`

## Requirements
- R1: While reset is asserted, `ale`, `p0_oe`, `rsp_valid` and `req_ready` are 0, and `psen_n`, `rd_n` and `wr_n` are 1.
- R2: Each accepted access starts at position 0. `ale` is high for exactly positions 0 and 1. `p0_oe` is 1 for positions 0 to 2, with `p0_out` equal to the low address byte, so the address is held one clock after `ale` falls.
- R3: A fetch (`req_kind` = 2'b00) drives `psen_n` low for positions 3 to 5, one clock after `ale` falls. `p0_oe` is 0 from position 3 to the end of the slot.
- R4: A data read (`req_kind` = 2'b01) drives `rd_n` low for positions 5 to 10, three clocks after `ale` falls. `p0_oe` is 0 from position 3 to 11.
- R5: A data write (`req_kind` = 2'b10) drives `wr_n` low for positions 5 to 10. `p0_oe` stays 1 and `p0_out` equals the write data for positions 3 to 11, which includes the clock after `wr_n` rises.
- R6: `p2_out` equals the high address byte at every position of an access.
- R7: `p0_in` is captured in the last clock in which `psen_n` or `rd_n` is low. `rsp_valid` is high for exactly the next clock (fetch position 6, read position 11), with `rsp_data` equal to the captured byte. A write gives no response.
- R8: The free-running position within the machine cycle is 0 in the first clock after reset. A fetch occupies 6 clocks and is accepted only when that position is 5 or 11. A read or write occupies 12 clocks and is accepted only when it is 11. `req_ready` is 0 at all other positions, and a request presented in time is accepted with no idle clock in between.
- R9: The reserved kind 2'b11 is never accepted: `req_ready` stays 0 and no `ale` pulse occurs.
- R10: At most one of `psen_n`, `rd_n` and `wr_n` is low at a time. `psen_n` stays high during data accesses, and `rd_n` and `wr_n` stay high during fetches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_kind | input | 2 | 00 fetch, 01 data read, 10 data write, 11 reserved |
| req_addr | input | 16 | Access address |
| req_wdata | input | 8 | Write data |
| req_ready | output | 1 | Request accepted at this clock edge |
| rsp_valid | output | 1 | Read data valid pulse |
| rsp_data | output | 8 | Captured fetch or read data |
| p0_out | output | 8 | Shared port value: low address or write data |
| p0_oe | output | 1 | Shared port drive enable |
| p0_in | input | 8 | Shared port sampled value |
| p2_out | output | 8 | High address byte |
| ale | output | 1 | Address latch strobe, active high |
| psen_n | output | 1 | Program read strobe, active low |
| rd_n | output | 1 | Data read strobe, active low |
| wr_n | output | 1 | Data write strobe, active low |

## Verification
The assertions check on every clock the strobe widths, the gap from the fall of `ale` to each strobe, that the port is not driven while a read strobe is low, the address and write-data hold clocks, that the strobes exclude each other, and that a response pulse lines up with a rising read strobe. Only the bench scenarios can show the things that depend on requests and data: that the returned byte is the one presented on the port, that the address bytes match the request, that acceptance lands on the correct slot boundaries, that back-to-back accesses leave no idle gap, and that the reserved kind is refused.

// File: rtl/mbus_pkg.sv
`timescale 1ns/1ps
// Package: shared timing constants and types for the external bus sequencer.
// Assumes a 12-clock machine cycle made of two equal fetch slots.
package mbus_pkg;
    localparam int CYCLE_CLKS = 12;
    localparam int SLOT_CLKS  = CYCLE_CLKS / 2;
    localparam int ALE_CLKS   = 2;
    localparam int ADDR_HOLD  = 1;
    localparam int PSEN_LAG   = 1;
    localparam int PSEN_CLKS  = 3;
    localparam int DSTB_LAG   = 3;
    localparam int DSTB_CLKS  = 6;
    localparam int POS_W      = $clog2(CYCLE_CLKS);

    typedef logic [POS_W-1:0] pos_t;

    localparam pos_t P_ALE_LAST   = pos_t'(ALE_CLKS - 1);
    localparam pos_t P_ADDR_LAST  = pos_t'(ALE_CLKS + ADDR_HOLD - 1);
    localparam pos_t P_PSEN_FIRST = pos_t'(ALE_CLKS + PSEN_LAG);
    localparam pos_t P_PSEN_LAST  = pos_t'(ALE_CLKS + PSEN_LAG + PSEN_CLKS - 1);
    localparam pos_t P_DSTB_FIRST = pos_t'(ALE_CLKS + DSTB_LAG);
    localparam pos_t P_DSTB_LAST  = pos_t'(ALE_CLKS + DSTB_LAG + DSTB_CLKS - 1);
    localparam pos_t P_FETCH_LAST = pos_t'(SLOT_CLKS - 1);
    localparam pos_t P_DATA_LAST  = pos_t'(CYCLE_CLKS - 1);

    typedef enum logic [1:0] {
        K_FETCH = 2'b00,
        K_READ  = 2'b01,
        K_WRITE = 2'b10,
        K_RSVD  = 2'b11
    } kind_e;

    typedef enum logic [1:0] {
        OP_IDLE,
        OP_FETCH,
        OP_READ,
        OP_WRITE
    } op_e;
endpackage

// File: rtl/mbus_phase.sv
`timescale 1ns/1ps
// Module: free-running position counter inside the machine cycle.
// Flags the last clock of each slot and of the whole cycle.
// Assumes position 0 in the first clock after reset.
module mbus_phase
    import mbus_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    output logic slot_end,
    output logic cycle_end
);
    pos_t tick;

    // Purpose: advance the position and wrap at the end of the machine cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tick <= '0;
        end else if (tick == P_DATA_LAST) begin
            tick <= '0;
        end else begin
            tick <= tick + pos_t'(1);
        end
    end

    // Purpose: decode the slot and cycle boundary flags.
    always_comb begin
        cycle_end = (tick == P_DATA_LAST);
        slot_end  = (tick == P_FETCH_LAST) || cycle_end;
    end
endmodule

// File: rtl/mbus_access.sv
`timescale 1ns/1ps
// Module: access state holder. Accepts requests on slot boundaries and
// keeps the running operation, its position and the latched address/data.
// Assumes accesses always start on a slot boundary, so they end on one.
module mbus_access
    import mbus_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slot_end,
    input  logic              cycle_end,
    input  logic              req_valid,
    input  logic [1:0]        req_kind,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output op_e               op_q,
    output pos_t              pos_q,
    output op_e               op_d,
    output pos_t              pos_d,
    output logic [ADDR_W-1:0] addr_d,
    output logic [DATA_W-1:0] wdata_d
);
    kind_e             kind;
    logic              data_mid;
    logic              fetch_mid;
    logic              accept;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;

    // Purpose: decide readiness from the boundary flags and the request kind.
    always_comb begin
        kind      = kind_e'(req_kind);
        data_mid  = ((op_q == OP_READ) || (op_q == OP_WRITE)) && (pos_q != P_DATA_LAST);
        fetch_mid = (op_q == OP_FETCH) && (pos_q != P_FETCH_LAST);
        req_ready = slot_end && !data_mid &&
                    ((kind == K_FETCH) ||
                     (cycle_end && ((kind == K_READ) || (kind == K_WRITE))));
        accept    = req_valid && req_ready;
    end

    // Purpose: compute the next operation, position and latched fields.
    always_comb begin
        op_d    = OP_IDLE;
        pos_d   = '0;
        addr_d  = addr_q;
        wdata_d = wdata_q;
        if (data_mid || fetch_mid) begin
            op_d  = op_q;
            pos_d = pos_q + pos_t'(1);
        end else if (accept) begin
            addr_d  = req_addr;
            wdata_d = req_wdata;
            case (kind)
                K_READ:  op_d = OP_READ;
                K_WRITE: op_d = OP_WRITE;
                default: op_d = OP_FETCH;
            endcase
        end
    end

    // Purpose: hold the access state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q    <= OP_IDLE;
            pos_q   <= '0;
            addr_q  <= '0;
            wdata_q <= '0;
        end else begin
            op_q    <= op_d;
            pos_q   <= pos_d;
            addr_q  <= addr_d;
            wdata_q <= wdata_d;
        end
    end
endmodule

// File: rtl/mbus_pins.sv
`timescale 1ns/1ps
// Module: registered bus pins and read-data capture.
// Pins are decoded from the next access state and registered, so each pin
// reflects the current position without combinational glitches.
// Assumes the access state of mbus_access as input.
module mbus_pins
    import mbus_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  op_e                      op_q,
    input  pos_t                     pos_q,
    input  op_e                      op_d,
    input  pos_t                     pos_d,
    input  logic [ADDR_W-1:0]        addr_d,
    input  logic [DATA_W-1:0]        wdata_d,
    input  logic [DATA_W-1:0]        p0_in,
    output logic [DATA_W-1:0]        p0_out,
    output logic                     p0_oe,
    output logic [ADDR_W-DATA_W-1:0] p2_out,
    output logic                     ale,
    output logic                     psen_n,
    output logic                     rd_n,
    output logic                     wr_n,
    output logic                     rsp_valid,
    output logic [DATA_W-1:0]        rsp_data
);
    logic busy_d, addr_ph_d, ale_d, psen_d, rd_d, wr_d, oe_d, cap;

    // Purpose: decode pin levels for the next position.
    always_comb begin
        busy_d    = (op_d != OP_IDLE);
        addr_ph_d = busy_d && (pos_d <= P_ADDR_LAST);
        ale_d     = busy_d && (pos_d <= P_ALE_LAST);
        psen_d    = (op_d == OP_FETCH) && (pos_d >= P_PSEN_FIRST) && (pos_d <= P_PSEN_LAST);
        rd_d      = (op_d == OP_READ)  && (pos_d >= P_DSTB_FIRST) && (pos_d <= P_DSTB_LAST);
        wr_d      = (op_d == OP_WRITE) && (pos_d >= P_DSTB_FIRST) && (pos_d <= P_DSTB_LAST);
        oe_d      = addr_ph_d || (op_d == OP_WRITE);
    end

    // Purpose: mark the last low clock of a read strobe for capture.
    always_comb begin
        cap = ((op_q == OP_FETCH) && (pos_q == P_PSEN_LAST)) ||
              ((op_q == OP_READ)  && (pos_q == P_DSTB_LAST));
    end

    // Purpose: register the bus pins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ale    <= 1'b0;
            psen_n <= 1'b1;
            rd_n   <= 1'b1;
            wr_n   <= 1'b1;
            p0_oe  <= 1'b0;
            p0_out <= '0;
            p2_out <= '0;
        end else begin
            ale    <= ale_d;
            psen_n <= !psen_d;
            rd_n   <= !rd_d;
            wr_n   <= !wr_d;
            p0_oe  <= oe_d;
            p0_out <= addr_ph_d ? addr_d[DATA_W-1:0] : wdata_d;
            p2_out <= addr_d[ADDR_W-1:DATA_W];
        end
    end

    // Purpose: capture returned data as the read strobe rises.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= cap;
            if (cap) begin
                rsp_data <= p0_in;
            end
        end
    end
endmodule

// File: rtl/mx_bus_seq.sv
`timescale 1ns/1ps
// Module: top of the multiplexed external bus sequencer.
// Takes fetch, read and write requests and plays them out as fixed-offset
// bus cycles inside a 12-clock machine cycle.
// Assumes the shared port tristate is built outside from p0_out/p0_oe.
module mx_bus_seq
    import mbus_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    input  logic [1:0]               req_kind,
    input  logic [ADDR_W-1:0]        req_addr,
    input  logic [DATA_W-1:0]        req_wdata,
    output logic                     req_ready,
    output logic                     rsp_valid,
    output logic [DATA_W-1:0]        rsp_data,
    output logic [DATA_W-1:0]        p0_out,
    output logic                     p0_oe,
    input  logic [DATA_W-1:0]        p0_in,
    output logic [ADDR_W-DATA_W-1:0] p2_out,
    output logic                     ale,
    output logic                     psen_n,
    output logic                     rd_n,
    output logic                     wr_n
);
    logic              slot_end, cycle_end;
    op_e               op_q, op_d;
    pos_t              pos_q, pos_d;
    logic [ADDR_W-1:0] addr_d;
    logic [DATA_W-1:0] wdata_d;

    mbus_phase u_phase (
        .clk       (clk),
        .rst_n     (rst_n),
        .slot_end  (slot_end),
        .cycle_end (cycle_end)
    );

    mbus_access #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_access (
        .clk       (clk),
        .rst_n     (rst_n),
        .slot_end  (slot_end),
        .cycle_end (cycle_end),
        .req_valid (req_valid),
        .req_kind  (req_kind),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .req_ready (req_ready),
        .op_q      (op_q),
        .pos_q     (pos_q),
        .op_d      (op_d),
        .pos_d     (pos_d),
        .addr_d    (addr_d),
        .wdata_d   (wdata_d)
    );

    mbus_pins #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pins (
        .clk       (clk),
        .rst_n     (rst_n),
        .op_q      (op_q),
        .pos_q     (pos_q),
        .op_d      (op_d),
        .pos_d     (pos_d),
        .addr_d    (addr_d),
        .wdata_d   (wdata_d),
        .p0_in     (p0_in),
        .p0_out    (p0_out),
        .p0_oe     (p0_oe),
        .p2_out    (p2_out),
        .ale       (ale),
        .psen_n    (psen_n),
        .rd_n      (rd_n),
        .wr_n      (wr_n),
        .rsp_valid (rsp_valid),
        .rsp_data  (rsp_data)
    );
endmodule

// File: rtl/mbus_chk.sv
`timescale 1ns/1ps
// Module: protocol checker for the bus pins, bound to mx_bus_seq.
// Counts strobe low widths and clocks since the address strobe to check
// edge offsets at every clock.
module mbus_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ale,
    input logic              psen_n,
    input logic              rd_n,
    input logic              wr_n,
    input logic              p0_oe,
    input logic [DATA_W-1:0] p0_out,
    input logic              rsp_valid
);
    logic [3:0] psen_lo, rd_lo, wr_lo, since_ale;

    // Purpose: track strobe low widths and clocks since the address strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            psen_lo   <= '0;
            rd_lo     <= '0;
            wr_lo     <= '0;
            since_ale <= '0;
        end else begin
            psen_lo   <= psen_n ? 4'd0 : ((psen_lo == 4'hF) ? psen_lo : psen_lo + 4'd1);
            rd_lo     <= rd_n   ? 4'd0 : ((rd_lo   == 4'hF) ? rd_lo   : rd_lo   + 4'd1);
            wr_lo     <= wr_n   ? 4'd0 : ((wr_lo   == 4'hF) ? wr_lo   : wr_lo   + 4'd1);
            since_ale <= ale    ? 4'd0 : ((since_ale == 4'hF) ? since_ale : since_ale + 4'd1);
        end
    end

    a_r2_ale_two_clocks: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ale) |=> (ale ##1 !ale));
    a_r2_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ale) |-> (p0_oe && $stable(p0_out)));
    a_r3_psen_lag: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(psen_n) |-> (since_ale == 4'd1));
    a_r3_psen_width: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(psen_n) |-> (psen_lo == 4'd3));
    a_r4_rd_lag: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rd_n) |-> (since_ale == 4'd3));
    a_r4_rd_width: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_n) |-> (rd_lo == 4'd6));
    a_r3_r4_port_released: assert property (@(posedge clk) disable iff (!rst_n)
        (!psen_n || !rd_n) |-> !p0_oe);
    a_r5_wr_lag: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wr_n) |-> (since_ale == 4'd3));
    a_r5_wr_width: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_n) |-> (wr_lo == 4'd6));
    a_r5_wdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_n) |-> (p0_oe && $stable(p0_out)));
    a_r7_rsp_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> ($rose(psen_n) || $rose(rd_n)));
    a_r10_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({~psen_n, ~rd_n, ~wr_n}) <= 1);
endmodule

bind mx_bus_seq mbus_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ale       (ale),
    .psen_n    (psen_n),
    .rd_n      (rd_n),
    .wr_n      (wr_n),
    .p0_oe     (p0_oe),
    .p0_out    (p0_out),
    .rsp_valid (rsp_valid)
);

// File: tb/sim_mx_bus_seq.sv
`timescale 1ns/1ps
// Bench: sweeps fetch/read/write accesses over many addresses and slot
// placements, comparing every pin at every position against the timing
// table computed from the requirements.
module sim_mx_bus_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_kind = 2'b00;
    logic [15:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        req_ready, rsp_valid, p0_oe, ale, psen_n, rd_n, wr_n;
    logic [7:0]  rsp_data, p0_out, p2_out;
    logic [7:0]  p0_in = '0;
    int          checks = 0;
    int          errors = 0;
    int          cyc = 0;

    always #2.5 clk = ~clk;

    mx_bus_seq u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .p0_out(p0_out),
        .p0_oe(p0_oe), .p0_in(p0_in), .p2_out(p2_out), .ale(ale),
        .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n)
    );

    // Position in the machine cycle seen at a falling edge is cyc % 12.
    always @(posedge clk) if (rst_n) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string rq, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
        end
    endtask

    function automatic logic [7:0] mem_byte(input logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h5A;
    endfunction

    // Compare every pin at each position of one access (starts at position 0).
    task automatic watch(input int kind, input logic [15:0] a,
                         input logic [7:0] wd, input logic [7:0] dat);
        int len = (kind == 0) ? 6 : 12;
        int rsp_at = (kind == 0) ? 6 : ((kind == 1) ? 11 : -1);
        for (int j = 0; j <= len; j++) begin
            @(negedge clk);
            if (j == 3 && kind != 2) p0_in = dat;
            if (j < len) begin
                chk(ale == (j < 2), "R2", "ale", ale, j < 2);
                chk(psen_n == !(kind == 0 && j >= 3 && j <= 5),
                    (kind == 0) ? "R3" : "R10", "psen_n", psen_n, !(kind == 0 && j >= 3 && j <= 5));
                chk(rd_n == !(kind == 1 && j >= 5 && j <= 10),
                    (kind == 1) ? "R4" : "R10", "rd_n", rd_n, !(kind == 1 && j >= 5 && j <= 10));
                chk(wr_n == !(kind == 2 && j >= 5 && j <= 10),
                    (kind == 2) ? "R5" : "R10", "wr_n", wr_n, !(kind == 2 && j >= 5 && j <= 10));
                chk(p0_oe == (j < 3 || kind == 2), (j < 3) ? "R2" : "R5", "p0_oe",
                    p0_oe, (j < 3 || kind == 2));
                if (j < 3) chk(p0_out == a[7:0], "R2", "low address", p0_out, a[7:0]);
                else if (kind == 2) chk(p0_out == wd, "R5", "write data", p0_out, wd);
                chk(p2_out == a[15:8], "R6", "high address", p2_out, a[15:8]);
            end
            if (j == rsp_at) begin
                chk(rsp_valid == 1'b1, "R7", "rsp_valid", rsp_valid, 1);
                chk(rsp_data == dat, "R7", "rsp_data", rsp_data, dat);
            end else if (j > 0 && j < len) begin
                chk(rsp_valid == 1'b0, "R7", "rsp_valid idle", rsp_valid, 0);
            end
        end
    endtask

    // Present one request, wait for acceptance, then watch it in the background.
    task automatic issue(input int kind, input logic [15:0] a, input logic [7:0] wd);
        int t;
        @(negedge clk);
        req_valid = 1'b1; req_kind = 2'(kind); req_addr = a; req_wdata = wd;
        #1;
        while (!req_ready) begin
            @(negedge clk);
            #1;
        end
        t = cyc % 12;
        if (kind == 0) chk(t == 5 || t == 11, "R8", "fetch start position", t, 5);
        else           chk(t == 11, "R8", "data start position", t, 11);
        @(posedge clk);
        #1 req_valid = 1'b0;
        fork
            watch(kind, a, wd, mem_byte(a));
        join_none
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (4) @(negedge clk);
        chk(ale == 0, "R1", "ale in reset", ale, 0);
        chk(psen_n && rd_n && wr_n, "R1", "strobes in reset", {psen_n, rd_n, wr_n}, 7);
        chk(p0_oe == 0, "R1", "p0_oe in reset", p0_oe, 0);
        chk(rsp_valid == 0, "R1", "rsp_valid in reset", rsp_valid, 0);
        chk(req_ready == 0, "R1", "req_ready in reset", req_ready, 0);
        rst_n = 1'b1;
        #1 chk(req_ready == 0, "R8", "ready at position 0", req_ready, 0);

        // R8: a data request at position 5 is not taken.
        while (cyc % 12 != 5) @(negedge clk);
        req_valid = 1'b1; req_kind = 2'b01; req_addr = 16'h4321;
        #1 chk(req_ready == 0, "R8", "data ready at position 5", req_ready, 0);
        issue(1, 16'h4321, 8'h00);

        // R9: reserved kind is refused.
        repeat (14) @(negedge clk);
        req_valid = 1'b1; req_kind = 2'b11; req_addr = 16'hBEEF;
        for (int k = 0; k < 14; k++) begin
            #1;
            chk(req_ready == 0, "R9", "ready for reserved kind", req_ready, 0);
            chk(ale == 0, "R9", "ale for reserved kind", ale, 0);
            @(negedge clk);
        end
        req_valid = 1'b0;

        // R8: back-to-back mixed sweep, no idle gap between accepted requests.
        for (int i = 0; i < 24; i++) begin
            int kind = (i % 4 == 1) ? 1 : ((i % 4 == 3) ? 2 : ((i >= 16) ? (i % 3) : 0));
            issue(kind, 16'(i * 16'h1357 + 16'h00A5), 8'(i * 37 + 3));
        end

        // Isolated accesses with idle gaps, boundary addresses.
        for (int k = 0; k < 3; k++) begin
            issue(k, 16'h0000, 8'hFF);
            repeat (17) @(negedge clk);
            issue(k, 16'hFFFF, 8'h00);
            repeat (23) @(negedge clk);
        end

        repeat (30) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule